// File: doc/BRIEF.md
# Sector Protection Register Manager

This block keeps one protection flag for each 64 KB sector of a 2 MB serial flash array, together with a single lock flag that freezes those flags. The command front end hands it decoded requests: protect one sector, unprotect one sector, or a status-byte write. A status-byte write can set or clear the lock flag and can protect or unprotect every sector at once. The write-protect pin input combines with the lock flag. A set lock flag with the pin asserted is a hardware lock, and only deasserting the pin allows the lock to be cleared. A set lock flag with the pin deasserted is a software lock, which any status-byte write can release.

The program and erase engine presents a target address and gets back, in the same cycle, whether that sector may be modified. A refused target makes the block pulse its write-enable-latch clear output on the following cycle. Every accepted request does the same, whether it changed any state or was ignored. The whole protection map, the lock flag and the hardware-lock indication are brought out for the status path.

Top module: `sprm_top`

## Requirements
- R1: After reset every sector flag reads 1 (protected), the lock flag reads 0, the hardware-lock indication reads 0 and the write-enable clear output reads 0.
- R2: A request of kind 0 (protect sector) with the lock flag at 0 sets the flag of the sector given by address bits [20:16], visible on protMap the cycle after the request; address bits [23:21] are ignored.
- R3: A request of kind 1 (unprotect sector) with the lock flag at 0 clears the flag of the sector given by address bits [20:16], visible the cycle after the request.
- R4: chkAllow is 1 exactly when the sector selected by chkAddr[20:16] has its flag at 0, in the same cycle; a check with chkValid high on a protected sector pulses welClear high on the next cycle, and a check on an unprotected sector does not.
- R5: While the lock flag is 1, requests of kind 0 and 1 and the global protect/unprotect part of a status write leave protMap unchanged.
- R6: hwLocked equals the lock flag AND wpActive; while both are 1, a status write (kind 2) leaves the lock flag at 1.
- R7: A status write (kind 2) with the lock flag at 0 sets every sector flag when data bits [5:2] are 1111, clears every sector flag when they are 0000, and leaves the map unchanged for any other value.
- R8: Every request with reqValid high and kind 0, 1 or 2 pulses welClear high on the next cycle; kind 3 is a no-op that changes no state and pulses nothing by itself.
- R9: A status write loads data bit 7 into the lock flag when the flag was 0, whatever the level of wpActive, and when the flag was 1 with wpActive low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe from the command front end, one cycle per request |
| reqKind | input | 2 | 0 protect sector, 1 unprotect sector, 2 status write, 3 no-op |
| reqAddr | input | 24 | Byte address naming the sector for kinds 0 and 1 |
| reqData | input | 8 | Status byte for kind 2: bit 7 lock value, bits [5:2] global code |
| wpActive | input | 1 | Write-protect pin level, 1 when asserted |
| chkValid | input | 1 | Program/erase target is being checked this cycle |
| chkAddr | input | 24 | Program/erase target address |
| chkAllow | output | 1 | Target sector is unprotected |
| welClear | output | 1 | One-cycle pulse asking for the write-enable latch to be cleared |
| protMap | output | 32 | Current protection flag of every sector, bit n for sector n |
| lockBit | output | 1 | Current lock flag |
| hwLocked | output | 1 | Lock flag set while the write-protect pin is asserted |

## Verification
The assertions assume that the front end presents at most one request per cycle, with reqKind and reqData stable while reqValid is high, and that wpActive is a synchronised level that does not glitch within a cycle. The stimulus meets this by driving every input once per cycle, shortly after the rising edge. It changes wpActive only between requests in the directed part and once per cycle in the random part. The random part draws request kinds, addresses, status bytes and pin levels freely. Lock-related transitions then occur with and without the pin asserted, and locked requests meet both protected and unprotected sectors.

// File: rtl/sprm_pkg.sv
package sprm_pkg;

  typedef enum logic [1:0] {
    REQ_PROT   = 2'd0,
    REQ_UNPROT = 2'd1,
    REQ_STAT   = 2'd2,
    REQ_NOP    = 2'd3
  } reqKind_e;

  // strobes from control to the protection map
  typedef struct packed {
    logic setOne;
    logic clrOne;
    logic setAll;
    logic clrAll;
  } mapStrb_t;

  localparam logic [3:0] GLOBAL_SET_CODE = 4'b1111;
  localparam logic [3:0] GLOBAL_CLR_CODE = 4'b0000;

endpackage

// File: rtl/sprm_ctrl.sv
module sprm_ctrl
  import sprm_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 5,
  parameter int DATA_W   = 8,
  parameter int LOCK_POS = 7,
  parameter int GLB_LSB  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              wpActive,
  input  logic              chkReject,
  output mapStrb_t          strb,
  output logic [SECT_W-1:0] sectIdx,
  output logic              lockBit,
  output logic              hwLocked,
  output logic              welClear
);

  reqKind_e    kind;
  logic        lockQ;
  logic        lockD;
  logic        welD;
  logic [3:0]  glbCode;
  logic        unusedBits;

  assign kind       = reqKind_e'(reqKind);
  assign sectIdx    = reqAddr[SECT_LSB +: SECT_W];
  assign glbCode    = reqData[GLB_LSB +: 4];
  assign unusedBits = ^{reqAddr, reqData};

  // decode requests into map strobes, gated by the lock
  always_comb begin
    strb = '0;
    if (reqValid && !lockQ) begin
      case (kind)
        REQ_PROT:   strb.setOne = 1'b1;
        REQ_UNPROT: strb.clrOne = 1'b1;
        REQ_STAT: begin
          if (glbCode == GLOBAL_SET_CODE)      strb.setAll = 1'b1;
          else if (glbCode == GLOBAL_CLR_CODE) strb.clrAll = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // lock flag: free while clear, pin-gated once set
  always_comb begin
    lockD = lockQ;
    if (reqValid && kind == REQ_STAT) begin
      if (!lockQ || !wpActive) lockD = reqData[LOCK_POS];
    end
  end

  assign welD = (reqValid && kind != REQ_NOP) || chkReject;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ    <= 1'b0;
      welClear <= 1'b0;
    end else begin
      lockQ    <= lockD;
      welClear <= welD;
    end
  end

  assign lockBit  = lockQ;
  assign hwLocked = lockQ & wpActive;

  p_hw_lock_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && wpActive) |=> lockQ);

  p_wel_after_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind != 2'd3) |=> welClear);

  p_lock_set_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!lockQ && reqValid && reqKind == 2'd2 && reqData[LOCK_POS]) |=> lockQ);

endmodule

// File: rtl/sprm_map.sv
module sprm_map
  import sprm_pkg::*;
#(
  parameter int NUM_SECT = 32,
  parameter int SECT_W   = 5,
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  mapStrb_t            strb,
  input  logic [SECT_W-1:0]   sectIdx,
  input  logic [ADDR_W-1:0]   chkAddr,
  output logic [NUM_SECT-1:0] protMap,
  output logic                chkAllow
);

  logic [NUM_SECT-1:0] mapQ;
  logic [SECT_W-1:0]   chkIdx;
  logic                unusedChk;

  for (genvar gi = 0; gi < NUM_SECT; gi++) begin : g_sect
    logic hitSel;
    assign hitSel = (sectIdx == SECT_W'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             mapQ[gi] <= 1'b1;
      else if (strb.setAll)                  mapQ[gi] <= 1'b1;
      else if (strb.clrAll)                  mapQ[gi] <= 1'b0;
      else if (strb.setOne && hitSel)        mapQ[gi] <= 1'b1;
      else if (strb.clrOne && hitSel)        mapQ[gi] <= 1'b0;
    end
  end

  assign chkIdx    = chkAddr[SECT_LSB +: SECT_W];
  assign chkAllow  = ~mapQ[chkIdx];
  assign protMap   = mapQ;
  assign unusedChk = ^chkAddr;

  p_set_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOne |=> protMap[$past(sectIdx)]);

  p_clr_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrOne |=> !protMap[$past(sectIdx)]);

  p_set_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setAll |=> (&protMap));

endmodule

// File: rtl/sprm_top.sv
module sprm_top
  import sprm_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int NUM_SECT = 32,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic                wpActive,
  input  logic                chkValid,
  input  logic [ADDR_W-1:0]   chkAddr,
  output logic                chkAllow,
  output logic                welClear,
  output logic [NUM_SECT-1:0] protMap,
  output logic                lockBit,
  output logic                hwLocked
);

  localparam int SECT_W = $clog2(NUM_SECT);

  mapStrb_t          strb;
  logic [SECT_W-1:0] sectIdx;
  logic              chkReject;

  assign chkReject = chkValid & ~chkAllow;

  sprm_ctrl #(
    .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W), .DATA_W(DATA_W),
    .LOCK_POS(7), .GLB_LSB(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .wpActive(wpActive),
    .chkReject(chkReject), .strb(strb), .sectIdx(sectIdx),
    .lockBit(lockBit), .hwLocked(hwLocked), .welClear(welClear)
  );

  sprm_map #(
    .NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)
  ) u_map (
    .clk(clk), .rstN(rstN), .strb(strb), .sectIdx(sectIdx),
    .chkAddr(chkAddr), .protMap(protMap), .chkAllow(chkAllow)
  );

  p_locked_map_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockBit && reqValid) |=> $stable(protMap));

  p_reject_wel_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !chkAllow) |=> welClear);

endmodule

// File: tb/sim_sprm_top.sv
module sim_sprm_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd3;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        wpActive = 1'b0;
  logic        chkValid = 1'b0;
  logic [23:0] chkAddr = '0;
  logic        chkAllow, welClear, lockBit, hwLocked;
  logic [31:0] protMap;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  logic [31:0] mMap;
  logic        mLock;
  logic        mWel;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprm_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .wpActive(wpActive),
    .chkValid(chkValid), .chkAddr(chkAddr), .chkAllow(chkAllow),
    .welClear(welClear), .protMap(protMap), .lockBit(lockBit), .hwLocked(hwLocked)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: one update per rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mMap = '1; mLock = 1'b0; mWel = 1'b0;
    end else begin
      mWel = (reqValid && reqKind != 2'd3) || (chkValid && mMap[chkAddr[20:16]]);
      if (reqValid) begin
        case (reqKind)
          2'd0: if (!mLock) mMap[reqAddr[20:16]] = 1'b1;
          2'd1: if (!mLock) mMap[reqAddr[20:16]] = 1'b0;
          2'd2: begin
            if (!mLock) begin
              if (reqData[5:2] == 4'b1111) mMap = '1;
              else if (reqData[5:2] == 4'b0000) mMap = '0;
              mLock = reqData[7];
            end else if (!wpActive) begin
              mLock = reqData[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curReq, " map"},  protMap, mMap);
      check({curReq, " lock"}, {31'd0, lockBit}, {31'd0, mLock});
      check("R6 hwLocked", {31'd0, hwLocked}, {31'd0, mLock & wpActive});
      check("R8 welClear", {31'd0, welClear}, {31'd0, mWel});
      check("R4 chkAllow", {31'd0, chkAllow}, {31'd0, ~mMap[chkAddr[20:16]]});
    end
  end

  task automatic step(input logic v, input logic [1:0] k, input logic [23:0] a,
                      input logic [7:0] d, input logic cv, input logic [23:0] ca,
                      input logic wp);
    @(posedge clk); #2;
    reqValid = v; reqKind = k; reqAddr = a; reqData = d;
    chkValid = cv; chkAddr = ca; wpActive = wp;
  endtask

  task automatic req(input logic [1:0] k, input logic [23:0] a,
                     input logic [7:0] d, input logic wp);
    step(1'b1, k, a, d, 1'b0, 24'h0, wp);
    step(1'b0, 2'd3, 24'h0, 8'h0, 1'b0, 24'h0, wp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk); #1;
    // R1: explicit reset state
    check("R1 reset map", protMap, 32'hFFFF_FFFF);
    check("R1 reset lock", {31'd0, lockBit}, 32'd0);
    check("R1 reset wel", {31'd0, welClear}, 32'd0);
    repeat (2) step(1'b0, 2'd3, 24'h0, 8'h0, 1'b0, 24'h0, 1'b0);

    curReq = "R3";
    req(2'd1, 24'h05_1234, 8'h0, 1'b0);
    req(2'd1, 24'hFF_0000, 8'h0, 1'b0);
    curReq = "R2";
    req(2'd0, 24'hE5_0000, 8'h0, 1'b0);

    // R4: checks on free and protected sectors
    step(1'b0, 2'd3, 24'h0, 8'h0, 1'b1, 24'h1F_FFFF, 1'b0);
    step(1'b0, 2'd3, 24'h0, 8'h0, 1'b1, 24'h00_0010, 1'b0);
    step(1'b0, 2'd3, 24'h0, 8'h0, 1'b0, 24'h0, 1'b0);

    curReq = "R8";
    step(1'b1, 2'd3, 24'h03_0000, 8'h3C, 1'b0, 24'h0, 1'b0);
    step(1'b0, 2'd3, 24'h0, 8'h0, 1'b0, 24'h0, 1'b0);

    curReq = "R7";
    req(2'd2, 24'h0, 8'h00, 1'b0);
    req(2'd2, 24'h0, 8'h14, 1'b0);
    req(2'd2, 24'h0, 8'h3C, 1'b0);
    req(2'd1, 24'h0A_0000, 8'h0, 1'b0);

    curReq = "R9";
    req(2'd2, 24'h0, 8'h94, 1'b1);
    curReq = "R6";
    req(2'd2, 24'h0, 8'h00, 1'b1);
    curReq = "R5";
    req(2'd0, 24'h0A_0000, 8'h0, 1'b1);
    req(2'd1, 24'h02_0000, 8'h0, 1'b0);
    req(2'd2, 24'h0, 8'hBC, 1'b0);
    curReq = "R9";
    req(2'd2, 24'h0, 8'h3C, 1'b0);
    curReq = "R2";
    req(2'd0, 24'h0A_0000, 8'h0, 1'b0);

    curReq = "R5";
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
           24'($urandom), 8'($urandom), $urandom_range(0, 1) == 1,
           24'($urandom), $urandom_range(0, 1) == 1);
    end
    step(1'b0, 2'd3, 24'h0, 8'h0, 1'b0, 24'h0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule